// File: doc/BRIEF.md
# Eight-Bit Staged Barrel Shifter

This block moves an 8-bit word left or right by any distance from 0 to 7 places within one combinational evaluation. It has no clock and no state: the output settles as soon as any input changes. This suits it to the shift path of an ALU, where a serial shifter would spend one cycle per place moved.

The distance is split into its three binary weights. Three cascaded stages each either pass their input through or move it by 1, 2 or 4 places, and each stage works on the result of the stage before it. Every output bit of a stage is a 4-to-1 mux. Its select is formed from the direction (high bit) and that stage's distance bit (low bit). A small control module turns the two mode inputs into the direction and the fill value that the datapath uses. On a right shift, vacated upper bits take zero for a logical shift or the original top data bit for an arithmetic shift. On a left shift, vacated lower bits always take zero.

Top module: `barrel_shift8`

## Requirements
- R1: `dirLeft` = 1 selects a shift toward the MSB and `dirLeft` = 0 selects a shift toward the LSB.
- R2: `arithSel` = 1 selects arithmetic mode and `arithSel` = 0 selects logical mode. The mode only affects the fill on right shifts.
- R3: The distance is the unsigned value of `shiftAmt`. Bit 0 contributes 1 place, bit 1 contributes 2 places and bit 2 contributes 4 places, and the three moves add together.
- R4: A logical right shift by n places fills the top n bits of `dataOut` with 0.
- R5: An arithmetic right shift by n places fills the top n bits of `dataOut` with `dataIn[7]`.
- R6: A left shift by n places fills the bottom n bits of `dataOut` with 0 in both modes.
- R7: When `shiftAmt` = 0, `dataOut` equals `dataIn` for every value of `dirLeft` and `arithSel`.
- R8: `dataOut` follows input changes combinationally, with no clock edge involved.
- R9: For every combination of data, distance, direction and mode, `dataOut` equals the shifted value defined by R1 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 8 | Word to be shifted |
| shiftAmt | input | 3 | Shift distance, 0 to 7 |
| dirLeft | input | 1 | 1 = left, 0 = right |
| arithSel | input | 1 | 1 = arithmetic, 0 = logical |
| dataOut | output | 8 | Shifted word |

## Verification
Every result is due in the same evaluation as the stimulus, zero cycles later, because no register lies on any path. The bench drives inputs on the falling edge of its pacing clock and samples one time unit later, well before the next rising edge. The R8 check deliberately changes the data with no edge in between and samples again. All 8192 input combinations are checked exhaustively, and a seeded random pass and some directed corner words are checked after that.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic moveLeft;  // 1: toward MSB
    logic fillBit;   // value entering vacated upper bits on right moves
  } shiftStrobes_t;
endpackage

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int W  = 8,
  parameter int SH = 1
) (
  input  logic [W-1:0] stageIn,
  input  logic         stageEn,
  input  logic         moveLeft,
  input  logic         fillBit,
  output logic [W-1:0] stageOut
);
  // One 4-to-1 mux per bit. sel = {moveLeft, stageEn}.
  // Inputs 0 and 2 pass through, 1 takes the upper neighbour, 3 the lower.
  logic [1:0] sel;
  assign sel = {moveLeft, stageEn};

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fromUpper;
    logic fromLower;
    if (i + SH < W) begin : g_up
      assign fromUpper = stageIn[i+SH];
    end else begin : g_upFill
      assign fromUpper = fillBit;
    end
    if (i >= SH) begin : g_lo
      assign fromLower = stageIn[i-SH];
    end else begin : g_loFill
      assign fromLower = 1'b0;
    end
    always_comb begin
      case (sel)
        2'd1:    stageOut[i] = fromUpper;
        2'd3:    stageOut[i] = fromLower;
        default: stageOut[i] = stageIn[i];
      endcase
    end
  end

  // A disabled stage leaves the word untouched (R3).
  always_comb begin
    if (!stageEn) begin
      p_stage_hold_r3: assert (stageOut == stageIn);
    end
  end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int W = 8,
  parameter int STAGES = $clog2(W)
) (
  input  logic              dirLeft,
  input  logic              arithSel,
  input  logic              topBit,
  input  logic [STAGES-1:0] shiftAmt,
  output shiftStrobes_t     strobes,
  output logic [STAGES-1:0] stageEn
);
  always_comb begin
    strobes.moveLeft = dirLeft;
    strobes.fillBit  = arithSel & topBit;
    stageEn          = shiftAmt;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int W = 8,
  parameter int STAGES = $clog2(W)
) (
  input  logic [W-1:0]      dataIn,
  input  shiftStrobes_t     strobes,
  input  logic [STAGES-1:0] stageEn,
  output logic [W-1:0]      dataOut
);
  logic [W-1:0] stageBus [0:STAGES];
  assign stageBus[0] = dataIn;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    shift_stage #(.W(W), .SH(1 << s)) i_stage (
      .stageIn (stageBus[s]),
      .stageEn (stageEn[s]),
      .moveLeft(strobes.moveLeft),
      .fillBit (strobes.fillBit),
      .stageOut(stageBus[s+1])
    );
  end

  assign dataOut = stageBus[STAGES];
endmodule

// File: rtl/barrel_shift8.sv
module barrel_shift8
  import shifter_pkg::*;
#(
  parameter int W = 8,
  localparam int STAGES = $clog2(W)
) (
  input  logic [W-1:0]      dataIn,
  input  logic [STAGES-1:0] shiftAmt,
  input  logic              dirLeft,
  input  logic              arithSel,
  output logic [W-1:0]      dataOut
);
  shiftStrobes_t     strobes;
  logic [STAGES-1:0] stageEn;

  shift_ctrl #(.W(W)) i_ctrl (
    .dirLeft (dirLeft),
    .arithSel(arithSel),
    .topBit  (dataIn[W-1]),
    .shiftAmt(shiftAmt),
    .strobes (strobes),
    .stageEn (stageEn)
  );

  shift_datapath #(.W(W)) i_dp (
    .dataIn (dataIn),
    .strobes(strobes),
    .stageEn(stageEn),
    .dataOut(dataOut)
  );

  always_comb begin
    if (shiftAmt == '0) begin
      p_zero_pass_r7: assert (dataOut == dataIn);
    end
    if (dirLeft && shiftAmt != '0) begin
      p_left_low_zero_r6: assert (dataOut[0] == 1'b0);
    end
    if (!dirLeft && shiftAmt != '0 && !arithSel) begin
      p_right_zero_fill_r4: assert (dataOut[W-1] == 1'b0);
    end
    if (!dirLeft && shiftAmt != '0 && arithSel) begin
      p_right_sign_fill_r5: assert (dataOut[W-1] == dataIn[W-1]);
    end
  end
endmodule

// File: tb/test_barrel_shift8.sv
module test_barrel_shift8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] dataIn = '0;
  logic [2:0] shiftAmt = '0;
  logic       dirLeft = 1'b0;
  logic       arithSel = 1'b0;
  logic [7:0] dataOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift8 i_barrel_shift8 (
    .dataIn(dataIn), .shiftAmt(shiftAmt), .dirLeft(dirLeft),
    .arithSel(arithSel), .dataOut(dataOut)
  );

  function automatic logic [7:0] refShift(input logic [7:0] d, input logic [2:0] a,
                                          input logic l, input logic ar);
    if (l) return d << a;
    if (ar) return 8'($signed(d) >>> a);
    return d >> a;
  endfunction

  function automatic string reqOf(input logic [2:0] a, input logic l, input logic ar);
    if (a == 0) return "R7";
    if (l) return "R6";
    if (ar) return "R5";
    return "R4";
  endfunction

  task automatic checkVal(input string req, input logic [7:0] exp);
    checks++;
    if (dataOut !== exp) begin
      fails++;
      $display("FAIL %s: din=%h amt=%0d left=%b arith=%b got %h expected %h",
               req, dataIn, shiftAmt, dirLeft, arithSel, dataOut, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [2:0] a, input logic l, input logic ar);
    @(negedge clk);
    dataIn = d; shiftAmt = a; dirLeft = l; arithSel = ar;
    #1;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    // Start-up state: all-zero inputs give zero output (R7).
    #1; checkVal("R7", 8'h00);
    // R1: direction encoding.
    apply(8'h01, 3'd1, 1'b1, 1'b0); checkVal("R1", 8'h02);
    apply(8'h80, 3'd1, 1'b0, 1'b0); checkVal("R1", 8'h40);
    // R2: mode changes only the right-shift fill.
    apply(8'h90, 3'd2, 1'b0, 1'b1); checkVal("R2", 8'hE4);
    apply(8'h90, 3'd2, 1'b1, 1'b1); checkVal("R2", 8'h40);
    // R3: stages compose, 5 = 4 + 1, 7 = 4 + 2 + 1.
    apply(8'h01, 3'd5, 1'b1, 1'b0); checkVal("R3", 8'h20);
    apply(8'hFF, 3'd7, 1'b0, 1'b0); checkVal("R3", 8'h01);
    apply(8'hFF, 3'd7, 1'b0, 1'b1); checkVal("R5", 8'hFF);
    apply(8'h7F, 3'd7, 1'b0, 1'b1); checkVal("R5", 8'h00);
    // R8: change the data with no clock edge between and sample again.
    apply(8'h0F, 3'd4, 1'b1, 1'b0); checkVal("R8", 8'hF0);
    #1 dataIn = 8'h03; #1 checkVal("R8", 8'h30);
    // R9: exhaustive sweep.
    for (int d = 0; d < 256; d++)
      for (int a = 0; a < 8; a++)
        for (int m = 0; m < 4; m++) begin
          apply(8'(d), 3'(a), m[1], m[0]);
          checkVal({"R9/", reqOf(3'(a), m[1], m[0])}, refShift(8'(d), 3'(a), m[1], m[0]));
        end
    // Seeded random pass (R9).
    for (int k = 0; k < 500; k++) begin
      logic [11:0] r;
      r = 12'($urandom);
      apply(r[7:0], r[10:8], r[11], 1'($urandom));
      checkVal("R9", refShift(dataIn, shiftAmt, dirLeft, arithSel));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule